// File: doc/BRIEF.md
# Trap Dispatch Sequencer

This block is the control sequence a 16-bit processor runs when it executes a system-call trap instruction, and the matching return. On a trap it takes an 8-bit service number and the program counter value that fetch has already advanced past the trap. It widens the service number with leading zeros to form an address in the bottom 256 words of memory, and reads the service-routine start address stored there. It then writes the saved return address into link register 7 and loads the program counter with the word it read.

A return request jumps through a link value supplied by the register file. While the block holds `busy` high, instruction fetch stays stalled. The sequence uses a memory port with a single-cycle read strobe and a ready input that may arrive any number of cycles later. It also drives a register-file write port and a program-counter load port.

Top module: `trap_seq`

## Requirements
- R1: During and after reset, `busy`, `memRdEn`, `regWrEn` and `pcLoad` are all low until a request arrives.
- R2: A trap request sampled while idle raises `memRdEn` for one cycle, two clock edges after the accepting edge, with `memAddr` equal to the trap vector in bits 7:0 and zero in bits 15:8.
- R3: After the read strobe, the sequence waits for `memRdy` for any number of cycles. It writes no register and loads no program counter before the ready edge.
- R4: In the cycle after the edge that samples `memRdy` high, `regWrEn` is high for one cycle with `regWrIdx` = 7 and `regWrData` equal to the `pcIn` value sampled when the trap was accepted.
- R5: In the cycle after the link write, `pcLoad` is high for one cycle with `pcNext` equal to the `memRdData` word sampled with `memRdy`.
- R6: `busy` is high from the cycle after trap acceptance through the `pcLoad` cycle. It is low in the cycle after `pcLoad`.
- R7: A return request sampled while idle raises `pcLoad` in the next cycle, with `pcNext` equal to the `linkVal` sampled with the request. It causes no memory read and no register write, and `busy` is high in that cycle only.
- R8: When a trap request and a return request are sampled in the same idle cycle, only the trap sequence runs.
- R9: Trap and return requests are accepted only in the idle state. Requests arriving while a sequence is in progress cause no additional strobes.
- R10: Changes on `pcIn` after trap acceptance do not alter the value written to the link register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | Start a trap sequence |
| trapVec | input | 8 | Service number for the trap |
| pcIn | input | 16 | Already-incremented program counter |
| retReq | input | 1 | Start a return |
| linkVal | input | 16 | Current link register contents |
| memRdEn | output | 1 | Table read strobe |
| memAddr | output | 16 | Table read address |
| memRdy | input | 1 | Table read data valid |
| memRdData | input | 16 | Table read data |
| regWrEn | output | 1 | Link register write strobe |
| regWrIdx | output | 3 | Register index written (always 7) |
| regWrData | output | 16 | Return address written |
| pcLoad | output | 1 | Program counter load strobe |
| pcNext | output | 16 | New program counter value |
| busy | output | 1 | Fetch stall while sequencing |

## Verification
Traps are run with vectors at both ends of the table (0x00 and 0xFF) and in the middle. Memory latencies of zero, one and several cycles show that the link write waits for ready and not for a fixed count. After acceptance `pcIn` is driven to a different value, which separates a captured return address from a live one. Back-to-back traps, a simultaneous trap and return, and requests raised mid-sequence check arbitration and the busy window. Returns with distinct link values confirm that the jump uses the link value sampled with the request and never touches memory.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALC,
    ST_READ,
    ST_WAIT,
    ST_LINK,
    ST_LOADPC,
    ST_DONE,
    ST_RET
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capTrap;   // latch vector and return address
    logic capRet;    // latch link value for a return
    logic formAddr;  // build table address
    logic grabWord;  // latch table word
    logic selRet;    // pcNext comes from link value
  } seqStrobe_t;

endpackage

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
  import trap_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       trapReq,
  input  logic       retReq,
  input  logic       memRdy,
  output seqStrobe_t strb,
  output logic       memRdEn,
  output logic       regWrEn,
  output logic       pcLoad,
  output logic       busy
);

  seqState_t curState, nxtState;

  always_ff @(posedge clk) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nxtState;
  end

  always_comb begin
    nxtState = curState;
    unique case (curState)
      ST_IDLE: begin
        if (trapReq)     nxtState = ST_CALC;
        else if (retReq) nxtState = ST_RET;
      end
      ST_CALC:   nxtState = ST_READ;
      ST_READ:   nxtState = ST_WAIT;
      ST_WAIT:   if (memRdy) nxtState = ST_LINK;
      ST_LINK:   nxtState = ST_LOADPC;
      ST_LOADPC: nxtState = ST_DONE;
      ST_DONE:   nxtState = ST_IDLE;
      ST_RET:    nxtState = ST_IDLE;
      default:   nxtState = ST_IDLE;
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.capTrap  = (curState == ST_IDLE) && trapReq;
    strb.capRet   = (curState == ST_IDLE) && retReq && !trapReq;
    strb.formAddr = (curState == ST_CALC);
    strb.grabWord = (curState == ST_WAIT) && memRdy;
    strb.selRet   = (curState == ST_RET);
  end

  assign memRdEn = (curState == ST_READ);
  assign regWrEn = (curState == ST_LINK);
  assign pcLoad  = (curState == ST_LOADPC) || (curState == ST_RET);
  assign busy    = (curState != ST_IDLE) && (curState != ST_DONE);

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn); // R2
  AST_LINK_AFTER_RDY: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_WAIT && memRdy) |=> regWrEn); // R4
  AST_NO_EARLY_LINK: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_WAIT && !memRdy) |=> !regWrEn && !pcLoad); // R3
  AST_PC_AFTER_LINK: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> pcLoad); // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRdEn, regWrEn, pcLoad})); // R9
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !busy); // R6

endmodule

// File: rtl/trap_seq_dp.sv
module trap_seq_dp
  import trap_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [VEC_W-1:0]  trapVec,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] linkVal,
  input  logic [ADDR_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] pcNext
);

  localparam int PAD_W = ADDR_W - VEC_W;

  logic [VEC_W-1:0]  vecReg;
  logic [ADDR_W-1:0] retAddrReg;
  logic [ADDR_W-1:0] tblAddrReg;
  logic [ADDR_W-1:0] targetReg;
  logic [ADDR_W-1:0] linkReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecReg     <= '0;
      retAddrReg <= '0;
      tblAddrReg <= '0;
      targetReg  <= '0;
      linkReg    <= '0;
    end else begin
      if (strb.capTrap) begin
        vecReg     <= trapVec;
        retAddrReg <= pcIn;
      end
      if (strb.formAddr) tblAddrReg <= {{PAD_W{1'b0}}, vecReg};
      if (strb.grabWord) targetReg  <= memRdData;
      if (strb.capRet)   linkReg    <= linkVal;
    end
  end

  assign memAddr   = tblAddrReg;
  assign regWrData = retAddrReg;
  assign pcNext    = strb.selRet ? linkReg : targetReg;

  AST_LINK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capTrap |=> $stable(retAddrReg)); // R10
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.grabWord |=> $stable(targetReg)); // R5

endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int VEC_W     = 8,
  parameter int REG_IDX_W = 3,
  parameter int LINK_REG  = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 trapReq,
  input  logic [VEC_W-1:0]     trapVec,
  input  logic [ADDR_W-1:0]    pcIn,
  input  logic                 retReq,
  input  logic [ADDR_W-1:0]    linkVal,
  output logic                 memRdEn,
  output logic [ADDR_W-1:0]    memAddr,
  input  logic                 memRdy,
  input  logic [ADDR_W-1:0]    memRdData,
  output logic                 regWrEn,
  output logic [REG_IDX_W-1:0] regWrIdx,
  output logic [ADDR_W-1:0]    regWrData,
  output logic                 pcLoad,
  output logic [ADDR_W-1:0]    pcNext,
  output logic                 busy
);

  localparam logic [REG_IDX_W-1:0] LINK_IDX = REG_IDX_W'(LINK_REG);

  seqStrobe_t strb;

  trap_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .trapReq (trapReq),
    .retReq  (retReq),
    .memRdy  (memRdy),
    .strb    (strb),
    .memRdEn (memRdEn),
    .regWrEn (regWrEn),
    .pcLoad  (pcLoad),
    .busy    (busy)
  );

  trap_seq_dp #(
    .ADDR_W (ADDR_W),
    .VEC_W  (VEC_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .trapVec   (trapVec),
    .pcIn      (pcIn),
    .linkVal   (linkVal),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .regWrData (regWrData),
    .pcNext    (pcNext)
  );

  assign regWrIdx = LINK_IDX;

endmodule

// File: tb/trap_seq_tb.sv
module trap_seq_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        trapReq;
  logic [7:0]  trapVec;
  logic [15:0] pcIn;
  logic        retReq;
  logic [15:0] linkVal;
  logic        memRdEn;
  logic [15:0] memAddr;
  logic        memRdy;
  logic [15:0] memRdData;
  logic        regWrEn;
  logic [2:0]  regWrIdx;
  logic [15:0] regWrData;
  logic        pcLoad;
  logic [15:0] pcNext;
  logic        busy;

  int errors = 0;
  int checks = 0;

  typedef struct {
    int          kind;  // 0 read, 1 link write, 2 pc load
    logic [15:0] val;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;

  trap_seq u_dut (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapVec(trapVec), .pcIn(pcIn),
    .retReq(retReq), .linkVal(linkVal), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdy(memRdy), .memRdData(memRdData), .regWrEn(regWrEn), .regWrIdx(regWrIdx),
    .regWrData(regWrData), .pcLoad(pcLoad), .pcNext(pcNext), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every strobe must match the head of the queue
  always @(negedge clk) begin
    if (rstN) begin
      int kind;
      logic [15:0] v;
      kind = -1;
      v = '0;
      if (memRdEn)      begin kind = 0; v = memAddr;   end
      else if (regWrEn) begin kind = 1; v = regWrData; end
      else if (pcLoad)  begin kind = 2; v = pcNext;    end
      if (kind >= 0) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9 unexpected strobe", 32'(kind), 32'hFFFF);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(e.kind == kind, {e.tag, " strobe kind"}, 32'(kind), 32'(e.kind));
          check(e.val == v, {e.tag, " value"}, 32'(v), 32'(e.val));
          if (kind == 1) check(regWrIdx == 3'd7, "R4 link index", 32'(regWrIdx), 32'd7);
        end
      end
    end
  end

  task automatic pushExp(input int kind, input logic [15:0] val, input string tag);
    expItem_t e;
    e.kind = kind; e.val = val; e.tag = tag;
    expQ.push_back(e);
  endtask

  // run one trap; alsoRet raises a return in the same cycle, midReq pokes requests while busy
  task automatic doTrap(input logic [7:0] vec, input logic [15:0] pc, input logic [15:0] word,
                        input int lat, input bit alsoRet, input bit midReq);
    pushExp(0, {8'h00, vec}, "R2");
    pushExp(1, pc, "R4");
    pushExp(2, word, "R5");
    @(negedge clk);
    trapReq = 1'b1; trapVec = vec; pcIn = pc;
    retReq = alsoRet; linkVal = 16'hDEAD;
    @(negedge clk);
    trapReq = midReq; retReq = midReq; trapVec = ~vec; pcIn = ~pc; // R10
    check(busy == 1'b1, "R6 busy after accept", 32'(busy), 32'd1);
    @(negedge clk);  // read cycle
    trapReq = 1'b0; retReq = 1'b0;
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      memRdy = 1'b0;
      check(busy == 1'b1, "R3 busy while waiting", 32'(busy), 32'd1);
    end
    @(negedge clk);
    memRdy = 1'b1; memRdData = word;
    @(negedge clk);  // link cycle
    memRdy = 1'b0; memRdData = 16'h0BAD;
    check(busy == 1'b1, "R6 busy at link", 32'(busy), 32'd1);
    @(negedge clk);  // pc load cycle
    check(busy == 1'b1, "R6 busy at pc load", 32'(busy), 32'd1);
    @(negedge clk);
    check(busy == 1'b0, "R6 busy after pc load", 32'(busy), 32'd0);
    @(negedge clk);
  endtask

  task automatic doRet(input logic [15:0] link);
    pushExp(2, link, "R7");
    @(negedge clk);
    retReq = 1'b1; linkVal = link;
    @(negedge clk);
    retReq = 1'b0; linkVal = ~link;
    check(busy == 1'b1, "R7 busy during return", 32'(busy), 32'd1);
    @(negedge clk);
    check(busy == 1'b0, "R7 busy after return", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; trapReq = 1'b0; trapVec = '0; pcIn = '0; retReq = 1'b0;
    linkVal = '0; memRdy = 1'b0; memRdData = '0;
    repeat (3) @(negedge clk);
    check(!busy && !memRdEn && !regWrEn && !pcLoad, "R1 outputs in reset",
          32'({busy, memRdEn, regWrEn, pcLoad}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !memRdEn && !regWrEn && !pcLoad, "R1 outputs after reset",
          32'({busy, memRdEn, regWrEn, pcLoad}), 32'd0);

    doTrap(8'h23, 16'h3005, 16'h0430, 0, 1'b0, 1'b0);  // R2 R4 R5
    doTrap(8'hFF, 16'h4001, 16'h1234, 3, 1'b0, 1'b0);  // R3 high vector
    doTrap(8'h00, 16'hFFFF, 16'hA5A5, 1, 1'b0, 1'b0);  // low vector
    doTrap(8'h21, 16'h3010, 16'h0500, 2, 1'b1, 1'b0);  // R8
    doTrap(8'h25, 16'h3020, 16'h0600, 4, 1'b0, 1'b1);  // R9
    doRet(16'h3006);                                   // R7
    doRet(16'hC0DE);
    doTrap(8'h7E, 16'h2222, 16'h7777, 0, 1'b0, 1'b0);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R9 queue drained", 32'(expQ.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule